// File: doc/BRIEF.md
# Bus-Idle Automatic Power-Down Controller

This block watches the address-latch strobe of a microcontroller bus. It puts a subsystem made of programmable logic and memories into power-down once the strobe has been quiet for a fixed number of input-clock periods. The idle timer is a saturating counter. A change on the strobe clears it, an active-low chip select clears it, and the block's synchronous reset clears it. Whichever of these clears the timer also takes the subsystem out of power-down on that same edge.

A small register pair holds the configuration. The first register holds the power-down enable, the turbo-disable bit, and two bits that block the clock and the strobe from the logic array. The second register holds one block bit for each of five bus control signals. The blocking bits only shape what reaches the logic array; the idle timer always runs on the unblocked input clock.

While power-down is active, the block asserts a memory-standby control and a bus-cut-off control. It also applies a fixed rule to each class of port: microcontroller I/O and logic-array outputs keep running unchanged, the address-out port freezes, and peripheral output enables are forced off.

Top module: `apd_ctrl`

## Requirements
- R1: Register 0 (reg_sel_i=0) keeps bit 1 = power-down enable, bit 3 = turbo off, bit 4 = block array clock, bit 5 = block array strobe. Register 1 (reg_sel_i=1) keeps bits 6..2, which block mcu_ctl_i[4..0]. All other bits read 0, and both registers reset to 0. reg_rdata_o shows, one cycle later, the register selected in the previous cycle, with its value from before any write in that cycle.
- R2: strobe_i and cs_n_i each pass through two synchronising flops. Any change of the synchronised strobe clears the idle counter. The counter saturates at 15 and does not wrap, so pd_o stays high for as long as the strobe stays idle.
- R3: With the block enabled, cs_n_i high and the strobe stable, pd_o rises exactly 18 rising edges after the edge that first samples the last strobe change. The counter clears on the 3rd of those edges and reaches 15 on the 18th.
- R4: Each wake condition clears pd_o and the counter on the same edge. The conditions are a synchronised strobe change, a synchronised cs_n_i low, and rst high. A cs_n_i held low keeps the counter at 0.
- R5: With the enable bit at 0, the counter stays at 0 and pd_o stays low.
- R6: mem_stby_o and bus_block_o are high exactly while pd_o is high.
- R7: arr_ctl_o, arr_strobe_o and arr_clk_en_o are registered copies of mcu_ctl_i, strobe_i and constant 1, each forced to 0 by its block bit. Power-down does not affect them.
- R8: Blocking the array clock does not stop the idle timer.
- R9: mio_o, pld_o and per_o are registered copies of their inputs, and power-down does not affect them. adr_o is a registered copy of adr_i that holds its value on every edge where pd is set. per_oe_o is per_oe_i registered, but forced to 0 whenever pd_o is high.
- R10: low_power_o shows the turbo-off bit. Its reset value is 0, which means turbo is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; it drives the idle timer and all registers |
| rst | input | 1 | Synchronous active-high reset, which is also a wake condition |
| strobe_i | input | 1 | Address-latch strobe from the microcontroller bus |
| cs_n_i | input | 1 | Active-low chip select, which is a wake condition |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 = control, 1 = block mask |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Registered read data |
| mcu_ctl_i | input | 5 | Bus control signals headed for the logic array |
| arr_ctl_o | output | 5 | Control signals after blocking |
| arr_strobe_o | output | 1 | Strobe after blocking |
| arr_clk_en_o | output | 1 | Enable that qualifies the array clock |
| pd_o | output | 1 | Power-down flag |
| mem_stby_o | output | 1 | Memory standby control |
| bus_block_o | output | 1 | Cuts the bus off from memory and logic |
| low_power_o | output | 1 | Turbo-off indication |
| mio_i | input | MIO_W | Microcontroller I/O data |
| mio_o | output | MIO_W | Microcontroller I/O pin drive |
| pld_i | input | PLD_W | Logic-array output data |
| pld_o | output | PLD_W | Logic-array output pin drive |
| adr_i | input | ADR_W | Address-out data |
| adr_o | output | ADR_W | Address-out pin drive |
| per_i | input | PER_W | Peripheral I/O data |
| per_o | output | PER_W | Peripheral I/O pin drive |
| per_oe_i | input | PER_W | Peripheral output enables |
| per_oe_o | output | PER_W | Peripheral output enables after power-down |

## Verification
The bench drives several strobe patterns and compares the outputs against a behavioural model on every cycle. An idle strobe shows where the counter reaches its threshold and that it saturates there. A single toggle, taken while the block is powered down, fixes the exact clear edge and the exact rise edge. A strobe that toggles every ten cycles has to keep the block awake indefinitely. Chip-select pulses, a held chip select and reset, each applied against a settled idle state, separate the three wake paths from strobe activity. The same idle pattern, repeated with the array clock blocked and with the enable cleared, tells a timer that runs on the ungated clock apart from one that follows the blocking bits or ignores the enable.

// File: rtl/apd_pkg.sv
package apd_pkg;
  localparam int REG_W = 8;
  localparam int CTL_W = 5;

  // bit positions inside the control register
  localparam int C0_APD_EN    = 1;
  localparam int C0_TURBO_OFF = 3;
  localparam int C0_CLK_BLK   = 4;
  localparam int C0_STB_BLK   = 5;
  // lowest bit of the control-signal block field in the mask register
  localparam int C2_CTL_LSB   = 2;

  typedef struct packed {
    logic             apd_en;
    logic             turbo_off;
    logic             clk_blk;
    logic             stb_blk;
    logic [CTL_W-1:0] ctl_blk;
  } cfg_t;
endpackage

// File: rtl/apd_regs.sv
module apd_regs
  import apd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we_i,
  input  logic             sel_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output cfg_t             cfg_o
);
  cfg_t             cfg_q;
  logic [REG_W-1:0] view0, view1, rdata_q;

  always_comb begin
    view0 = '0;
    view0[C0_APD_EN]    = cfg_q.apd_en;
    view0[C0_TURBO_OFF] = cfg_q.turbo_off;
    view0[C0_CLK_BLK]   = cfg_q.clk_blk;
    view0[C0_STB_BLK]   = cfg_q.stb_blk;
    view1 = '0;
    view1[C2_CTL_LSB +: CTL_W] = cfg_q.ctl_blk;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '0;
      rdata_q <= '0;
    end else begin
      rdata_q <= sel_i ? view1 : view0;
      if (we_i) begin
        if (sel_i) begin
          cfg_q.ctl_blk <= wdata_i[C2_CTL_LSB +: CTL_W];
        end else begin
          cfg_q.apd_en    <= wdata_i[C0_APD_EN];
          cfg_q.turbo_off <= wdata_i[C0_TURBO_OFF];
          cfg_q.clk_blk   <= wdata_i[C0_CLK_BLK];
          cfg_q.stb_blk   <= wdata_i[C0_STB_BLK];
        end
      end
    end
  end

  logic unused_wbits;
  assign unused_wbits = ^{wdata_i[7], wdata_i[0]};

  assign rdata_o = rdata_q;
  assign cfg_o   = cfg_q;
endmodule

// File: rtl/apd_sync.sv
module apd_sync #(
  parameter int           W       = 2,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[0] <= RST_VAL;
        else     stg[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= RST_VAL;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/apd_timer.sv
module apd_timer #(
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             strobe_i,
  input  logic             cs_n_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wake_o,
  output logic             pd_d_o,
  output logic             pd_q_o
);
  localparam logic [CNT_W-1:0] LIMIT = {CNT_W{1'b1}};

  logic [1:0]       sync_q;
  logic             stb_prev;
  logic             activity, wake;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pd_q, pd_d;

  // bit 1 is the chip select, which idles high
  apd_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) i_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({cs_n_i, strobe_i}),
    .q_o (sync_q)
  );

  always_comb begin
    activity = sync_q[0] ^ stb_prev;
    wake     = activity | ~sync_q[1];
    if (!en_i || wake)       cnt_d = '0;
    else if (cnt_q != LIMIT) cnt_d = cnt_q + 1'b1;
    else                     cnt_d = cnt_q;
    pd_d = (cnt_d == LIMIT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      pd_q     <= 1'b0;
      stb_prev <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      pd_q     <= pd_d;
      stb_prev <= sync_q[0];
    end
  end

  assign cnt_o  = cnt_q;
  assign wake_o = wake;
  assign pd_d_o = pd_d;
  assign pd_q_o = pd_q;
endmodule

// File: rtl/apd_arr_gate.sv
module apd_arr_gate
  import apd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  cfg_t             cfg_i,
  input  logic [CTL_W-1:0] ctl_i,
  input  logic             strobe_i,
  output logic [CTL_W-1:0] ctl_o,
  output logic             strobe_o,
  output logic             clk_en_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_o    <= '0;
      strobe_o <= 1'b0;
      clk_en_o <= 1'b0;
    end else begin
      ctl_o    <= ctl_i & ~cfg_i.ctl_blk;
      strobe_o <= strobe_i & ~cfg_i.stb_blk;
      clk_en_o <= ~cfg_i.clk_blk;
    end
  end

  logic unused_cfg;
  assign unused_cfg = cfg_i.apd_en ^ cfg_i.turbo_off;
endmodule

// File: rtl/apd_port_ctl.sv
module apd_port_ctl #(
  parameter int MIO_W = 8,
  parameter int PLD_W = 8,
  parameter int ADR_W = 8,
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pd_next_i,
  input  logic [MIO_W-1:0] mio_i,
  input  logic [PLD_W-1:0] pld_i,
  input  logic [ADR_W-1:0] adr_i,
  input  logic [PER_W-1:0] per_i,
  input  logic [PER_W-1:0] per_oe_i,
  output logic [MIO_W-1:0] mio_o,
  output logic [PLD_W-1:0] pld_o,
  output logic [ADR_W-1:0] adr_o,
  output logic [PER_W-1:0] per_o,
  output logic [PER_W-1:0] per_oe_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mio_o    <= '0;
      pld_o    <= '0;
      adr_o    <= '0;
      per_o    <= '0;
      per_oe_o <= '0;
    end else begin
      mio_o    <= mio_i;
      pld_o    <= pld_i;
      per_o    <= per_i;
      if (!pd_next_i) adr_o <= adr_i;
      per_oe_o <= pd_next_i ? '0 : per_oe_i;
    end
  end
endmodule

// File: rtl/apd_ctrl.sv
module apd_ctrl
  import apd_pkg::*;
#(
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int MIO_W       = 8,
  parameter int PLD_W       = 8,
  parameter int ADR_W       = 8,
  parameter int PER_W       = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe_i,
  input  logic             cs_n_i,
  input  logic             reg_we_i,
  input  logic             reg_sel_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic [CTL_W-1:0] mcu_ctl_i,
  output logic [CTL_W-1:0] arr_ctl_o,
  output logic             arr_strobe_o,
  output logic             arr_clk_en_o,
  output logic             pd_o,
  output logic             mem_stby_o,
  output logic             bus_block_o,
  output logic             low_power_o,
  input  logic [MIO_W-1:0] mio_i,
  output logic [MIO_W-1:0] mio_o,
  input  logic [PLD_W-1:0] pld_i,
  output logic [PLD_W-1:0] pld_o,
  input  logic [ADR_W-1:0] adr_i,
  output logic [ADR_W-1:0] adr_o,
  input  logic [PER_W-1:0] per_i,
  output logic [PER_W-1:0] per_o,
  input  logic [PER_W-1:0] per_oe_i,
  output logic [PER_W-1:0] per_oe_o
);
  cfg_t             cfg;
  logic [CNT_W-1:0] idle_cnt;
  logic             wake;
  logic             pd_next, pd_q;

  apd_regs i_regs (
    .clk     (clk),
    .rst     (rst),
    .we_i    (reg_we_i),
    .sel_i   (reg_sel_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .cfg_o   (cfg)
  );

  apd_timer #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) i_timer (
    .clk      (clk),
    .rst      (rst),
    .en_i     (cfg.apd_en),
    .strobe_i (strobe_i),
    .cs_n_i   (cs_n_i),
    .cnt_o    (idle_cnt),
    .wake_o   (wake),
    .pd_d_o   (pd_next),
    .pd_q_o   (pd_q)
  );

  apd_arr_gate i_gate (
    .clk      (clk),
    .rst      (rst),
    .cfg_i    (cfg),
    .ctl_i    (mcu_ctl_i),
    .strobe_i (strobe_i),
    .ctl_o    (arr_ctl_o),
    .strobe_o (arr_strobe_o),
    .clk_en_o (arr_clk_en_o)
  );

  apd_port_ctl #(.MIO_W(MIO_W), .PLD_W(PLD_W), .ADR_W(ADR_W), .PER_W(PER_W)) i_ports (
    .clk       (clk),
    .rst       (rst),
    .pd_next_i (pd_next),
    .mio_i     (mio_i),
    .pld_i     (pld_i),
    .adr_i     (adr_i),
    .per_i     (per_i),
    .per_oe_i  (per_oe_i),
    .mio_o     (mio_o),
    .pld_o     (pld_o),
    .adr_o     (adr_o),
    .per_o     (per_o),
    .per_oe_o  (per_oe_o)
  );

  assign pd_o        = pd_q;
  assign mem_stby_o  = pd_q;
  assign bus_block_o = pd_q;
  assign low_power_o = cfg.turbo_off;
endmodule

// File: rtl/apd_ctrl_chk.sv
module apd_ctrl_chk #(
  parameter int CNT_W = 4,
  parameter int PER_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cs_n_i,
  input logic             pd_o,
  input logic [PER_W-1:0] per_oe_o,
  input logic             apd_en,
  input logic             clk_blk,
  input logic             wake,
  input logic [CNT_W-1:0] idle_cnt
);
  localparam logic [CNT_W-1:0] LIMIT = {CNT_W{1'b1}};

  a_r2_saturate: assert property (@(posedge clk) disable iff (rst)
    idle_cnt == LIMIT |=> (idle_cnt == LIMIT || idle_cnt == '0));

  a_r3_rise_at_limit: assert property (@(posedge clk) disable iff (rst)
    $rose(pd_o) |-> $past(idle_cnt) == LIMIT - 1'b1);

  a_r4_cs_wakes: assert property (@(posedge clk) disable iff (rst)
    !cs_n_i |=> ##2 !pd_o);

  a_r5_disabled_idle: assert property (@(posedge clk) disable iff (rst)
    !apd_en |=> !pd_o);

  a_r8_timer_ungated: assert property (@(posedge clk) disable iff (rst)
    (clk_blk && apd_en && !wake && idle_cnt != LIMIT)
      |=> idle_cnt == $past(idle_cnt) + 1'b1);

  a_r9_per_off: assert property (@(posedge clk) disable iff (rst)
    pd_o |-> per_oe_o == '0);
endmodule

bind apd_ctrl apd_ctrl_chk #(.CNT_W(CNT_W), .PER_W(PER_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cs_n_i   (cs_n_i),
  .pd_o     (pd_o),
  .per_oe_o (per_oe_o),
  .apd_en   (cfg.apd_en),
  .clk_blk  (cfg.clk_blk),
  .wake     (wake),
  .idle_cnt (idle_cnt)
);

// File: tb/test_apd_ctrl.sv
module test_apd_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       strobe = 1'b0, cs_n = 1'b1, we = 1'b0, sel = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic [4:0] ctl = '0, arr_ctl;
  logic       arr_stb, arr_clk_en, pd, mstby, bblk, lowp;
  logic [7:0] mio = '0, pld = '0, adr = '0, per = '0, per_oe = '0;
  logic [7:0] mio_q, pld_q, adr_q, per_q, per_oe_q;

  int vectors = 0, fails = 0;
  bit started = 0, done = 0;

  always #10 clk = ~clk;

  apd_ctrl i_apd_ctrl (
    .clk(clk), .rst(rst), .strobe_i(strobe), .cs_n_i(cs_n),
    .reg_we_i(we), .reg_sel_i(sel), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .mcu_ctl_i(ctl), .arr_ctl_o(arr_ctl), .arr_strobe_o(arr_stb),
    .arr_clk_en_o(arr_clk_en), .pd_o(pd), .mem_stby_o(mstby),
    .bus_block_o(bblk), .low_power_o(lowp),
    .mio_i(mio), .mio_o(mio_q), .pld_i(pld), .pld_o(pld_q),
    .adr_i(adr), .adr_o(adr_q), .per_i(per), .per_o(per_q),
    .per_oe_i(per_oe), .per_oe_o(per_oe_q)
  );

  // behavioural reference, updated on each rising edge
  int         m_cnt;
  bit         m_pd, m_en, m_turbo, m_cblk, m_sblk;
  bit [4:0]   m_mask, m_actl;
  bit [7:0]   m_rd, m_mio, m_pld, m_adr, m_per, m_oe;
  bit         m_astb, m_aclk;
  bit         stb_hist[$];
  bit         cs_hist[$];

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_pd = 0; m_en = 0; m_turbo = 0; m_cblk = 0; m_sblk = 0;
      m_mask = 0; m_actl = 0; m_rd = 0; m_mio = 0; m_pld = 0; m_adr = 0;
      m_per = 0; m_oe = 0; m_astb = 0; m_aclk = 0;
      stb_hist = '{0, 0, 0};
      cs_hist  = '{1, 1};
    end else begin
      bit woke;
      woke = (stb_hist[1] != stb_hist[2]) || !cs_hist[1];
      if (!m_en || woke) m_cnt = 0;
      else if (m_cnt < 15) m_cnt++;
      m_pd  = (m_cnt == 15);
      m_actl = ctl & ~m_mask;
      m_astb = strobe & !m_sblk;
      m_aclk = !m_cblk;
      m_mio = mio; m_pld = pld; m_per = per;
      if (!m_pd) m_adr = adr;
      m_oe = m_pd ? 8'h00 : per_oe;
      m_rd = sel ? {1'b0, m_mask, 2'b00} : {2'b00, m_sblk, m_cblk, m_turbo, 1'b0, m_en, 1'b0};
      if (we) begin
        if (sel) m_mask = wdata[6:2];
        else begin
          m_en = wdata[1]; m_turbo = wdata[3]; m_cblk = wdata[4]; m_sblk = wdata[5];
        end
      end
      void'(stb_hist.pop_back());
      stb_hist.push_front(strobe);
      void'(cs_hist.pop_back());
      cs_hist.push_front(cs_n);
    end
    started = 1;
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    if (started && !done) begin
      chk("R1", "rdata", rdata, m_rd);
      chk("R3", "pd", pd, m_pd);
      chk("R6", "mem_stby", mstby, m_pd);
      chk("R6", "bus_block", bblk, m_pd);
      chk("R7", "arr_ctl", arr_ctl, m_actl);
      chk("R7", "arr_strobe", arr_stb, m_astb);
      chk("R7", "arr_clk_en", arr_clk_en, m_aclk);
      chk("R10", "low_power", lowp, m_turbo);
      chk("R9", "mio", mio_q, m_mio);
      chk("R9", "pld", pld_q, m_pld);
      chk("R9", "adr", adr_q, m_adr);
      chk("R9", "per", per_q, m_per);
      chk("R9", "per_oe", per_oe_q, m_oe);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(bit s, logic [7:0] d);
    we = 1; sel = s; wdata = d;
    tick(1);
    we = 0; wdata = '0;
  endtask

  task automatic rd(bit s);
    sel = s;
    tick(1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    int first_low, first_high;
    tick(3);
    rst = 0;
    tick(1);
    // reset state
    chk("R1", "reset ctrl read", rdata, 8'h00);
    chk("R10", "reset turbo on", lowp, 1'b0);
    chk("R3", "reset pd", pd, 1'b0);

    // R1: implemented bits only
    wr(0, 8'hFF); rd(0);
    chk("R1", "ctrl0 readback", rdata, 8'h3A);
    chk("R10", "turbo off shown", lowp, 1'b1);
    wr(1, 8'hFF); rd(1);
    chk("R1", "ctrl2 readback", rdata, 8'h7C);
    wr(1, 8'h00);
    wr(0, 8'h02);

    // R3: idle strobe reaches power-down
    mio = 8'h11; pld = 8'h22; adr = 8'h33; per = 8'h44; per_oe = 8'hFF;
    tick(25);
    chk("R3", "pd after idle", pd, 1'b1);
    chk("R6", "mem standby", mstby, 1'b1);
    chk("R9", "per_oe off", per_oe_q, 8'h00);
    // R9: ports during power-down
    adr = 8'h99; mio = 8'h5A; pld = 8'hA5;
    tick(2);
    chk("R9", "adr frozen", adr_q, 8'h33);
    chk("R9", "mio follows", mio_q, 8'h5A);
    chk("R9", "pld follows", pld_q, 8'hA5);
    // R2: saturation
    tick(40);
    chk("R2", "pd stays after saturation", pd, 1'b1);

    // R3/R4 exact timing of a single strobe toggle
    strobe = ~strobe;
    first_low = 0; first_high = 0;
    for (int k = 1; k <= 30; k++) begin
      tick(1);
      if (!pd && first_low == 0) first_low = k;
      if (pd && first_low != 0 && first_high == 0) first_high = k;
    end
    chk("R4", "strobe wake edge", first_low, 3);
    chk("R3", "pd rise edge", first_high, 18);
    chk("R9", "adr updates awake", adr_q, 8'h99);

    // R4: chip-select pulse wakes
    cs_n = 0; tick(1); cs_n = 1;
    tick(3);
    chk("R4", "cs pulse wake", pd, 1'b0);
    tick(20);
    chk("R4", "re-enter after cs", pd, 1'b1);
    // R4: cs held low keeps awake
    cs_n = 0; tick(30);
    chk("R4", "cs held low", pd, 1'b0);
    cs_n = 1;

    // R2: periodic activity prevents power-down
    for (int k = 0; k < 6; k++) begin
      strobe = ~strobe; tick(10);
      chk("R2", "periodic strobe awake", pd, 1'b0);
    end

    // R8/R7: blocked array clock, timer still runs
    wr(0, 8'h12);
    tick(20);
    chk("R8", "pd with clock blocked", pd, 1'b1);
    chk("R7", "array clock blocked", arr_clk_en, 1'b0);

    // R7: control and strobe blocking
    wr(1, 8'h54);
    ctl = 5'h1F; tick(2);
    chk("R7", "ctl blocked pattern", arr_ctl, 5'b01010);
    wr(0, 8'h22);
    strobe = 1; tick(2);
    chk("R7", "strobe blocked", arr_stb, 1'b0);
    wr(0, 8'h02); wr(1, 8'h00);
    tick(2);
    chk("R7", "strobe passes", arr_stb, 1'b1);
    chk("R7", "ctl passes", arr_ctl, 5'h1F);

    // R5: disabled
    wr(0, 8'h00);
    tick(40);
    chk("R5", "disabled no pd", pd, 1'b0);

    // R4: reset wakes and clears registers
    wr(0, 8'h0A);
    tick(20);
    chk("R3", "pd before reset", pd, 1'b1);
    rst = 1; tick(1); rst = 0;
    chk("R4", "reset wake", pd, 1'b0);
    rd(0);
    chk("R4", "reset clears ctrl", rdata, 8'h00);
    chk("R10", "reset turbo on again", lowp, 1'b0);
    tick(2);
    finish_run();
  end
endmodule